// File: doc/BRIEF.md
# Shift and Bit-Manipulation Unit

A purely combinational 32-bit datapath slice for a small processor core. It takes an operation code, two register operands, a 5-bit immediate and the current carry flag. It returns a 32-bit result, a new carry value, a carry-write enable and an illegal-operation flag. The unit handles register-amount and immediate shifts, rotates (including a one-bit rotate through carry), leading-zero counting, bit reversal, single-bit generation, low-order mask generation, byte extraction, sign and zero extension, and a test for a zero byte.

The surrounding pipeline presents the operands and reads the outputs in the same cycle. It writes `result_o` to the destination register. It writes `carry_o` to the flag register only when `carry_we_o` is high. If `illegal_o` is high it raises an exception.

Register-amount shifts do not wrap when the amount is out of range. They saturate. An immediate of zero turns each immediate shift and the rotate into a one-bit move through carry.

Top module: `shift_bit_unit`

## Requirements
- R1: Logical shift right (op 0) and left (op 1) by `b_i` give zero when `b_i` is greater than 31. Otherwise they give `a_i` shifted by `b_i[4:0]`.
- R2: Arithmetic shift right by register (op 2) gives all ones for a negative `a_i` and zero otherwise when `b_i` is greater than 30. Otherwise it gives the sign-filling shift by `b_i`.
- R3: Rotate immediate (op 3) with `imm_i`=0 gives `{carry_i, a_i[31:1]}` and writes `a_i[0]` to carry. With a nonzero `imm_i` it gives `a_i` rotated left by `imm_i` and leaves carry unchanged.
- R4: The immediate arithmetic-right (op 4), logical-left (op 5) and logical-right (op 6) shifts move by `imm_i` bits and leave carry unchanged. With `imm_i`=0 they move by one bit and write the bit shifted out to carry: bit 0 for the right shifts, bit 31 for the left shift.
- R5: Find-first-one (op 7) returns the count of zero bits above the highest set bit of `a_i`, counting down from bit 31. It returns 32 for a zero operand.
- R6: Bit reverse (op 8) returns `a_i` with bit i moved to bit 31-i.
- R7: Bit generate (op 9) returns zero when `b_i[5]` is set. Otherwise it returns a word with a single one at bit `b_i[4:0]`.
- R8: Mask immediate (op 10) returns all ones for `imm_i`=0 and (1<<`imm_i`)-1 for `imm_i` from 8 to 31. For `imm_i` from 1 to 7 it raises `illegal_o`.
- R9: Byte extract (op 11) returns byte n of `a_i`, meaning bits 8n+7..8n with n=`imm_i[1:0]`, zero-extended. It writes carry with whether `a_i` is nonzero.
- R10: Zero-extend byte (op 12), sign-extend byte (op 13), zero-extend halfword (op 14) and sign-extend halfword (op 15) extend the low 8 or 16 bits of `a_i`.
- R11: The zero-byte test (op 16) writes carry as 1 only when all four bytes of `a_i` are nonzero. Its result is zero.
- R12: `carry_we_o` is high only for ops 3 to 6 with `imm_i`=0, and for ops 11 and 16. Whenever it is low, `carry_o` equals `carry_i`.
- R13: Op codes 17 to 31 and the reserved masks raise `illegal_o`. They give a zero result and hold `carry_we_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 32 | Operand being shifted or manipulated |
| b_i | input | 32 | Register shift amount or bit index |
| imm_i | input | 5 | Immediate amount, mask width or byte number |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | New carry value |
| carry_we_o | output | 1 | Carry-write enable |
| illegal_o | output | 1 | Illegal or reserved operation |

## Verification
Every output is a function of the present inputs alone, so each result is due in the same cycle in which its stimulus is applied, with zero register stages. The bench changes inputs just after a falling clock edge. It samples all four outputs one nanosecond later, well before the next rising edge, so no check can straddle an input change. The bench sweeps every op code across a set of operand patterns, every immediate and a band of shift amounts that spans both saturation points and some very large values.

// File: rtl/sbu_pkg.sv
// Package: shared widths and operation codes for the shift and bit unit.
// Assumes a 32-bit datapath; the code values are fixed by the decoder.
package sbu_pkg;
    localparam int XLEN   = 32;
    localparam int SHW    = $clog2(XLEN);
    localparam int OPW    = 5;
    localparam int NLANE  = XLEN / 8;
    localparam int LW     = $clog2(NLANE);

    localparam logic [OPW-1:0] OP_LSR_R  = 5'd0;
    localparam logic [OPW-1:0] OP_LSL_R  = 5'd1;
    localparam logic [OPW-1:0] OP_ASR_R  = 5'd2;
    localparam logic [OPW-1:0] OP_ROT_I  = 5'd3;
    localparam logic [OPW-1:0] OP_ASR_I  = 5'd4;
    localparam logic [OPW-1:0] OP_LSL_I  = 5'd5;
    localparam logic [OPW-1:0] OP_LSR_I  = 5'd6;
    localparam logic [OPW-1:0] OP_FF1    = 5'd7;
    localparam logic [OPW-1:0] OP_BREV   = 5'd8;
    localparam logic [OPW-1:0] OP_BGEN_R = 5'd9;
    localparam logic [OPW-1:0] OP_MASK_I = 5'd10;
    localparam logic [OPW-1:0] OP_XTRB   = 5'd11;
    localparam logic [OPW-1:0] OP_ZEXTB  = 5'd12;
    localparam logic [OPW-1:0] OP_SEXTB  = 5'd13;
    localparam logic [OPW-1:0] OP_ZEXTH  = 5'd14;
    localparam logic [OPW-1:0] OP_SEXTH  = 5'd15;
    localparam logic [OPW-1:0] OP_TSTNBZ = 5'd16;
endpackage

// File: rtl/sbu_shift.sv
// Module: shifts and rotates (ops 0..6).
// Register amounts saturate instead of wrapping. A zero immediate makes the
// immediate forms a one-bit move through carry. Claims no other op.
module sbu_shift
    import sbu_pkg::*;
(
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [SHW-1:0]  imm_i,
    input  logic            carry_i,
    output logic [XLEN-1:0] res_o,
    output logic            cnew_o,
    output logic            cwe_o,
    output logic            hit_o
);
    logic            big_lsh;
    logic            big_asr;
    logic [SHW-1:0]  ramt;
    logic [SHW-1:0]  iamt;
    logic            izero;
    logic [SHW:0]    rot_back;

    // Decode range limits and the effective immediate amount.
    always_comb begin
        big_lsh  = (b_i > XLEN'(XLEN - 1));
        big_asr  = (b_i > XLEN'(XLEN - 2));
        ramt     = b_i[SHW-1:0];
        izero    = (imm_i == '0);
        iamt     = izero ? SHW'(1) : imm_i;
        rot_back = (SHW+1)'(XLEN) - {1'b0, imm_i};
    end

    // Select the shift or rotate result and any carry update.
    always_comb begin
        res_o  = '0;
        cnew_o = 1'b0;
        cwe_o  = 1'b0;
        hit_o  = 1'b1;
        case (op_i)
            OP_LSR_R: res_o = big_lsh ? '0 : (a_i >> ramt);
            OP_LSL_R: res_o = big_lsh ? '0 : (a_i << ramt);
            OP_ASR_R: res_o = big_asr ? {XLEN{a_i[XLEN-1]}}
                                      : XLEN'($signed(a_i) >>> ramt);
            OP_ROT_I: begin
                if (izero) begin
                    res_o  = {carry_i, a_i[XLEN-1:1]};
                    cnew_o = a_i[0];
                    cwe_o  = 1'b1;
                end else begin
                    res_o = (a_i << imm_i) | (a_i >> rot_back);
                end
            end
            OP_ASR_I: begin
                res_o  = XLEN'($signed(a_i) >>> iamt);
                cnew_o = a_i[0];
                cwe_o  = izero;
            end
            OP_LSL_I: begin
                res_o  = a_i << iamt;
                cnew_o = a_i[XLEN-1];
                cwe_o  = izero;
            end
            OP_LSR_I: begin
                res_o  = a_i >> iamt;
                cnew_o = a_i[0];
                cwe_o  = izero;
            end
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sbu_bits.sv
// Module: bit-level operations (ops 7..10): leading-zero count, reverse,
// single-bit generate and low mask. Flags the reserved mask widths.
// Never writes carry.
module sbu_bits
    import sbu_pkg::*;
(
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [SHW:0]    b_i,
    input  logic [SHW-1:0]  imm_i,
    output logic [XLEN-1:0] res_o,
    output logic            ill_o,
    output logic            hit_o
);
    logic [SHW:0]    lz_cnt;
    logic [XLEN-1:0] rev;

    // Count zeros above the highest set bit; the top set bit is taken last.
    always_comb begin
        lz_cnt = (SHW+1)'(XLEN);
        for (int i = 0; i < XLEN; i++)
            if (a_i[i]) lz_cnt = (SHW+1)'(XLEN - 1 - i);
    end

    // Mirror the operand bit order.
    always_comb begin
        for (int i = 0; i < XLEN; i++)
            rev[i] = a_i[XLEN-1-i];
    end

    // Select the bit-level result and flag reserved mask widths.
    always_comb begin
        res_o = '0;
        ill_o = 1'b0;
        hit_o = 1'b1;
        case (op_i)
            OP_FF1:    res_o = XLEN'(lz_cnt);
            OP_BREV:   res_o = rev;
            OP_BGEN_R: res_o = b_i[SHW] ? '0 : (XLEN'(1) << b_i[SHW-1:0]);
            OP_MASK_I: begin
                if (imm_i == '0)
                    res_o = '1;
                else if (imm_i < SHW'(8))
                    ill_o = 1'b1;
                else
                    res_o = ~({XLEN{1'b1}} << imm_i);
            end
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sbu_bytes.sv
// Module: byte-lane operations (ops 11..16): byte extract, extensions and
// the zero-byte test. Splits the operand into lanes with a generate loop.
module sbu_bytes
    import sbu_pkg::*;
(
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [LW-1:0]   lane_i,
    output logic [XLEN-1:0] res_o,
    output logic            cnew_o,
    output logic            cwe_o,
    output logic            hit_o
);
    logic [7:0]       lane [NLANE];
    logic [NLANE-1:0] lane_nz;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane[g]    = a_i[g*8 +: 8];
        assign lane_nz[g] = |a_i[g*8 +: 8];
    end

    // Select the byte-lane result and carry update.
    always_comb begin
        res_o  = '0;
        cnew_o = 1'b0;
        cwe_o  = 1'b0;
        hit_o  = 1'b1;
        case (op_i)
            OP_XTRB: begin
                res_o  = XLEN'(lane[lane_i]);
                cnew_o = |lane_nz;
                cwe_o  = 1'b1;
            end
            OP_ZEXTB: res_o = XLEN'(a_i[7:0]);
            OP_SEXTB: res_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
            OP_ZEXTH: res_o = XLEN'(a_i[15:0]);
            OP_SEXTH: res_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
            OP_TSTNBZ: begin
                cnew_o = &lane_nz;
                cwe_o  = 1'b1;
            end
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/shift_bit_unit.sv
// Module: top of the shift and bit unit. Combinational. Routes each op to the
// one sub-unit that claims it, quiets everything on an illegal op and passes
// the incoming carry through when no carry write happens.
module shift_bit_unit
    import sbu_pkg::*;
(
    input  logic [4:0]  op_i,
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    input  logic [4:0]  imm_i,
    input  logic        carry_i,
    output logic [31:0] result_o,
    output logic        carry_o,
    output logic        carry_we_o,
    output logic        illegal_o
);
    logic [XLEN-1:0] sh_res, bt_res, by_res;
    logic            sh_c, sh_we, sh_hit;
    logic            bt_ill, bt_hit;
    logic            by_c, by_we, by_hit;

    sbu_shift u_shift (
        .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .carry_i(carry_i),
        .res_o(sh_res), .cnew_o(sh_c), .cwe_o(sh_we), .hit_o(sh_hit)
    );

    sbu_bits u_bits (
        .op_i(op_i), .a_i(a_i), .b_i(b_i[SHW:0]), .imm_i(imm_i),
        .res_o(bt_res), .ill_o(bt_ill), .hit_o(bt_hit)
    );

    sbu_bytes u_bytes (
        .op_i(op_i), .a_i(a_i), .lane_i(imm_i[LW-1:0]),
        .res_o(by_res), .cnew_o(by_c), .cwe_o(by_we), .hit_o(by_hit)
    );

    // Merge sub-unit outputs and apply illegal and carry-hold rules.
    always_comb begin
        result_o   = '0;
        carry_o    = carry_i;
        carry_we_o = 1'b0;
        illegal_o  = 1'b0;
        if (sh_hit) begin
            result_o   = sh_res;
            carry_we_o = sh_we;
            if (sh_we) carry_o = sh_c;
        end else if (bt_hit) begin
            illegal_o = bt_ill;
            result_o  = bt_ill ? '0 : bt_res;
        end else if (by_hit) begin
            result_o   = by_res;
            carry_we_o = by_we;
            if (by_we) carry_o = by_c;
        end else begin
            illegal_o = 1'b1;
        end
    end
endmodule

// File: rtl/shift_bit_unit_chk.sv
// Module: checker for the shift and bit unit. Holds port-level rules that
// must hold for every input combination. It is bound to the top below.
module shift_bit_unit_chk (
    input logic [4:0]  op_i,
    input logic [31:0] a_i,
    input logic [31:0] b_i,
    input logic [4:0]  imm_i,
    input logic        carry_i,
    input logic [31:0] result_o,
    input logic        carry_o,
    input logic        carry_we_o,
    input logic        illegal_o
);
    // Check port relations whenever any input or output settles.
    always_comb begin
        p_carry_hold_r12: assert (carry_we_o || (carry_o == carry_i))
            else $error("carry changed without write enable");
        p_illegal_quiet_r13: assert (!illegal_o || (!carry_we_o && result_o == 32'd0))
            else $error("illegal op produced output");
        p_lshift_sat_r1: assert (!((op_i == 5'd0 || op_i == 5'd1) && b_i > 32'd31) || result_o == 32'd0)
            else $error("logical shift did not saturate");
        p_asr_fill_r2: assert (!(op_i == 5'd2 && b_i > 32'd30) || result_o == {32{a_i[31]}})
            else $error("arithmetic shift did not sign fill");
        p_ff1_range_r5: assert (op_i != 5'd7 || (result_o <= 32'd32 && (a_i != 32'd0 || result_o == 32'd32)))
            else $error("find-first-one out of range");
        p_bgen_onehot_r7: assert (op_i != 5'd9 || ($onehot0(result_o) && (!b_i[5] || result_o == 32'd0)))
            else $error("bit generate not one-hot");
        p_rot_we_r3: assert (op_i != 5'd3 || (carry_we_o == (imm_i == 5'd0)))
            else $error("rotate carry enable wrong");
        p_zextb_upper_r10: assert (op_i != 5'd12 || result_o[31:8] == 24'd0)
            else $error("zero extend left upper bits");
    end
endmodule

bind shift_bit_unit shift_bit_unit_chk u_chk (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o), .carry_we_o(carry_we_o),
    .illegal_o(illegal_o)
);

// File: tb/shift_bit_unit_tb.sv
// Bench: sweeps every op code over operand patterns, immediates and shift
// amounts, and compares with a bit-by-bit reference model.
module shift_bit_unit_tb;
    logic        clk = 1'b0;
    logic [4:0]  op;
    logic [31:0] a, b;
    logic [4:0]  imm;
    logic        cin;
    logic [31:0] res;
    logic        cout, cwe, ill;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    shift_bit_unit u_dut (
        .op_i(op), .a_i(a), .b_i(b), .imm_i(imm), .carry_i(cin),
        .result_o(res), .carry_o(cout), .carry_we_o(cwe), .illegal_o(ill)
    );

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'd0, 5'd1: return "R1";
            5'd2:       return "R2";
            5'd3:       return "R3";
            5'd4, 5'd5, 5'd6: return "R4";
            5'd7:       return "R5";
            5'd8:       return "R6";
            5'd9:       return "R7";
            5'd10:      return "R8";
            5'd11:      return "R9";
            5'd12, 5'd13, 5'd14, 5'd15: return "R10";
            5'd16:      return "R11";
            default:    return "R13";
        endcase
    endfunction

    function automatic logic [31:0] srl1(input logic [31:0] v, input int n, input logic fill);
        logic [31:0] t = v;
        for (int k = 0; k < n; k++) t = {fill, t[31:1]};
        return t;
    endfunction

    function automatic logic [31:0] sll1(input logic [31:0] v, input int n);
        logic [31:0] t = v;
        for (int k = 0; k < n; k++) t = {t[30:0], 1'b0};
        return t;
    endfunction

    // Reference model written from the requirements.
    task automatic model(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [4:0] im, input logic c,
                         output logic [31:0] er, output logic ec, output logic ew, output logic ei);
        int n;
        er = 32'd0; ec = c; ew = 1'b0; ei = 1'b0;
        n = (im == 5'd0) ? 1 : int'(im);
        case (o)
            5'd0: er = (y > 32'd31) ? 32'd0 : srl1(x, int'(y), 1'b0);
            5'd1: er = (y > 32'd31) ? 32'd0 : sll1(x, int'(y));
            5'd2: er = srl1(x, (y > 32'd31) ? 32 : int'(y), x[31]);
            5'd3: begin
                if (im == 5'd0) begin
                    er = {c, x[31:1]}; ec = x[0]; ew = 1'b1;
                end else begin
                    er = x;
                    for (int k = 0; k < int'(im); k++) er = {er[30:0], er[31]};
                end
            end
            5'd4: begin er = srl1(x, n, x[31]); if (im == 5'd0) begin ec = x[0]; ew = 1'b1; end end
            5'd5: begin er = sll1(x, n); if (im == 5'd0) begin ec = x[31]; ew = 1'b1; end end
            5'd6: begin er = srl1(x, n, 1'b0); if (im == 5'd0) begin ec = x[0]; ew = 1'b1; end end
            5'd7: begin
                er = 32'd0;
                while (er < 32'd32 && x[31 - int'(er)] == 1'b0) er = er + 32'd1;
            end
            5'd8: for (int k = 0; k < 32; k++) er[31-k] = x[k];
            5'd9: er = y[5] ? 32'd0 : sll1(32'd1, int'(y[4:0]));
            5'd10: begin
                if (im == 5'd0) er = 32'hFFFF_FFFF;
                else if (im < 5'd8) ei = 1'b1;
                else er = 32'(64'd2 ** int'(im) - 64'd1);
            end
            5'd11: begin
                er = (x / (32'd1 << (8 * int'(im[1:0])))) % 32'd256;
                ec = (x != 32'd0); ew = 1'b1;
            end
            5'd12: er = x % 32'd256;
            5'd13: er = (x[7]) ? (x % 32'd256) + 32'hFFFF_FF00 : x % 32'd256;
            5'd14: er = x % 32'd65536;
            5'd15: er = (x[15]) ? (x % 32'd65536) + 32'hFFFF_0000 : x % 32'd65536;
            5'd16: begin
                ec = (x[31:24] != 0) && (x[23:16] != 0) && (x[15:8] != 0) && (x[7:0] != 0);
                ew = 1'b1;
            end
            default: ei = 1'b1;
        endcase
    endtask

    // Apply one stimulus after a falling edge and check it 1 ns later.
    task automatic apply(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [4:0] im, input logic c);
        logic [31:0] er; logic ec, ew, ei;
        string rq;
        @(negedge clk);
        op = o; a = x; b = y; imm = im; cin = c;
        model(o, x, y, im, c, er, ec, ew, ei);
        rq = req_of(o);
        #1;
        n_chk = n_chk + 1;
        if (res !== er || ill !== ei) begin
            n_fail = n_fail + 1;
            $display("FAIL %s op=%0d a=%h b=%h imm=%0d: result %h ill %b expected %h ill %b",
                     rq, o, x, y, im, res, ill, er, ei);
        end
        n_chk = n_chk + 1;
        if (cwe !== ew || cout !== ec) begin
            n_fail = n_fail + 1;
            $display("FAIL %s op=%0d a=%h imm=%0d cin=%b: carry %b we %b expected %b we %b",
                     ew ? rq : "R12", o, x, im, c, cout, cwe, ec, ew);
        end
    endtask

    logic [31:0] pats [8];
    logic [31:0] bvals [45];

    initial begin
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0001; pats[3] = 32'h1234_5678;
        pats[4] = 32'hF00D_00A5; pats[5] = 32'h7FFF_FFFE;
        pats[6] = 32'h0101_0101; pats[7] = 32'h00C3_8000;
        for (int k = 0; k < 41; k++) bvals[k] = 32'(k);
        bvals[41] = 32'd63; bvals[42] = 32'd255;
        bvals[43] = 32'h8000_0000; bvals[44] = 32'hFFFF_FFFF;

        // Quiet state: all-zero inputs decode as a register shift of zero.
        op = 5'd0; a = 32'd0; b = 32'd0; imm = 5'd0; cin = 1'b0;
        apply(5'd0, 32'd0, 32'd0, 5'd0, 1'b0);

        // Main sweep: all ops, patterns, amounts and both carry values.
        for (int o = 0; o < 32; o++)
            for (int p = 0; p < 8; p++)
                for (int k = 0; k < 45; k++)
                    for (int c = 0; c < 2; c++)
                        apply(5'(o), pats[p], bvals[k], 5'(k), 1'(c));

        // R5 and R6: each single set bit and each single clear bit.
        for (int i = 0; i < 32; i++) begin
            apply(5'd7, 32'd1 << i, 32'd0, 5'd0, 1'b0);
            apply(5'd7, ~(32'd1 << i), 32'd0, 5'd0, 1'b1);
            apply(5'd8, 32'd1 << i, 32'd0, 5'd0, 1'b0);
        end

        // R11: one zero byte in each lane position.
        for (int i = 0; i < 4; i++)
            apply(5'd16, 32'hFFFF_FFFF & ~(32'hFF << (8 * i)), 32'd0, 5'd0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule